// File: doc/BRIEF.md
# External Bus Width Access Splitter

This block sits between a 64-bit internal bus and a narrower external memory bus. It takes one internal access of 16, 32 or 64 bits and turns it into one, two or four external cycles, depending on whether the target region is 16 or 32 bits wide. Each region supplies three settings with the request: a port width code, an address-alignment enable and a big-endian select. The block latches these settings when it accepts the request, so they may change while a sequence runs.

For every external cycle the block works out the byte address of the piece being moved and converts it to the external address. It then places the matching half-word or word of the internal data on the low lanes of the external data bus. On reads it writes each returned half-word or word back into its own lane of a 64-bit result. When the last cycle has been acknowledged it raises a one-cycle done pulse, and the assembled read data is valid in that same cycle. In big-endian 16-bit regions the two half-words of each 32-bit word go out odd half first. A request with a reserved port width or size code raises an error pulse and starts no external cycle. External timing, chip-select decoding, wait states and arbitration are handled elsewhere.

Top module: `ext_width_splitter`

## Requirements
- R1: A request accepted with port width code 00 or 11, or with size code 3, raises `err` for exactly the one cycle after acceptance. It starts no external cycle (`ext_valid` stays low) and gives no `done`.
- R2: In a 16-bit region (port width code 01) with `cfg_big_endian` low, the size codes 0 (16-bit), 1 (32-bit) and 2 (64-bit) give 1, 2 and 4 external cycles. The byte addresses start at the request address with its low bits below the access size cleared, and rise in steps of 2 (low bits 000, 010, 100, 110 for a 64-bit access).
- R3: In a 16-bit region with `cfg_big_endian` high, a 64-bit access issues low byte-address bits 010, 000, 110, 100 in that order, and a 32-bit access issues 10 then 00. A single 16-bit access uses its own address.
- R4: In a 32-bit region (port width code 10), a 64-bit access gives two cycles at byte offsets 0 and then 4 from the 8-byte-aligned address. A 32-bit or 16-bit access gives one cycle.
- R5: With `cfg_align` low, `ext_addr` equals bits [23:0] of the cycle's byte address.
- R6: With `cfg_align` high, `ext_addr` equals byte-address bits [24:1] in a 16-bit region and bits [25:2] in a 32-bit region.
- R7: On writes in a 16-bit region, `ext_wdata[15:0]` carries internal data bits [16*s+15:16*s], where s is byte-address bits [2:1], and `ext_wdata[31:16]` is zero. In a 32-bit region, `ext_wdata` carries internal bits [32*b+31:32*b], where b is byte-address bit 2.
- R8: On reads, every lane of `rdata` not covered by an external cycle of the request is zero. Every covered lane holds the returned data: `ext_rdata[15:0]` in a 16-bit region, and the whole `ext_rdata` word in a 32-bit region, placed on the lane given by the same rule as R7.
- R9: `done` pulses high for one cycle, in the cycle after the acknowledgement of the last external cycle, and read `rdata` is valid in that cycle.
- R10: `req_ready` is low from acceptance until the sequence ends, and requests presented meanwhile are ignored. `ext_valid`, `ext_addr` and `ext_wdata` hold steady until `ext_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Internal request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 = 16-bit, 1 = 32-bit, 2 = 64-bit, 3 reserved |
| req_addr | input | IADDR_W (26) | Internal byte address |
| req_wdata | input | 64 | Internal write data |
| cfg_portw | input | 2 | Region width: 01 = 16-bit, 10 = 32-bit, 00/11 reserved |
| cfg_align | input | 1 | Convert byte address to half-word/word address |
| cfg_big_endian | input | 1 | Big-endian half-word ordering in 16-bit regions |
| ext_valid | output | 1 | External cycle requested |
| ext_write | output | 1 | External cycle direction |
| ext_addr | output | EADDR_W (24) | External address |
| ext_wdata | output | 32 | External write data, low lanes used |
| ext_ack | input | 1 | External cycle completed |
| ext_rdata | input | 32 | External read data |
| done | output | 1 | Sequence finished pulse |
| rdata | output | 64 | Assembled read data |
| err | output | 1 | Reserved code pulse |

## Verification
The bench goes after the big-endian swap. A design that swapped every access, or never swapped, would send a lone 16-bit item to the wrong half-word, or issue 000 before 010. It covers both alignment shifts, where an off-by-one shift puts cycles at doubled or halved addresses, and it moves the region settings while a sequence runs, which shows up any design that fails to latch them. Reserved codes must give an error with no bus cycle. Long acknowledge delays with a request held during the wait would expose a design that accepts while busy or lets the address drift. Read data from a previous access must not leak into lanes the current request never touched.

// File: rtl/ews_pkg.sv
// Package: shared widths and codes for the external bus width splitter.
// Assumes a 64-bit internal data path and a 32-bit external data bus.
package ews_pkg;
    localparam int IDATA_W = 64;
    localparam int EDATA_W = 32;
    localparam int HW_W    = 16;

    localparam logic [1:0] PW_16 = 2'b01;
    localparam logic [1:0] PW_32 = 2'b10;

    localparam logic [1:0] SZ_16 = 2'd0;
    localparam logic [1:0] SZ_32 = 2'd1;
    localparam logic [1:0] SZ_64 = 2'd2;

    typedef enum logic {
        ST_IDLE,
        ST_BUS
    } ews_state_t;
endpackage

// File: rtl/ews_beat_plan.sv
// Module: ews_beat_plan
// Decodes the request size and region width into the index of the last
// external cycle, the low address bits to clear, and a reserved-code flag.
// Assumes the codes defined in ews_pkg; purely combinational.
module ews_beat_plan
    import ews_pkg::*;
(
    input  logic [1:0] size,
    input  logic [1:0] portw,
    output logic       bad,
    output logic       w16,
    output logic [1:0] last_idx,
    output logic [2:0] low_clear
);
    // Classify the codes and pick the cycle count.
    always_comb begin
        w16       = (portw == PW_16);
        bad       = !((portw == PW_16) || (portw == PW_32)) || (size == 2'd3);
        last_idx  = 2'd0;
        low_clear = 3'b001;
        case (size)
            SZ_16: begin
                last_idx  = 2'd0;
                low_clear = 3'b001;
            end
            SZ_32: begin
                last_idx  = w16 ? 2'd1 : 2'd0;
                low_clear = 3'b011;
            end
            SZ_64: begin
                last_idx  = w16 ? 2'd3 : 2'd1;
                low_clear = 3'b111;
            end
            default: begin
                last_idx  = 2'd0;
                low_clear = 3'b111;
            end
        endcase
    end
endmodule

// File: rtl/ews_addr_gen.sv
// Module: ews_addr_gen
// Forms the byte address of the current external cycle from the aligned
// base and the cycle index. Applies the big-endian half-word swap in 16-bit
// regions, then the optional half-word or word address conversion.
// Assumes IADDR_W >= EADDR_W + 2 and a base with its low bits already cleared.
module ews_addr_gen #(
    parameter int IADDR_W = 26,
    parameter int EADDR_W = 24
) (
    input  logic [IADDR_W-1:0] base,
    input  logic [1:0]         idx,
    input  logic [1:0]         last_idx,
    input  logic               w16,
    input  logic               big_endian,
    input  logic               align,
    output logic [IADDR_W-1:0] byte_addr,
    output logic [EADDR_W-1:0] ext_addr
);
    localparam int PAD_W = IADDR_W - 3;

    logic [1:0] order;
    logic [2:0] offset;

    // Reorder cycles, build the byte offset and convert the address.
    always_comb begin
        order     = (big_endian && (last_idx != 2'd0)) ? (idx ^ 2'b01) : idx;
        offset    = w16 ? {order, 1'b0} : {idx[0], 2'b00};
        byte_addr = base | {{PAD_W{1'b0}}, offset};
        if (!align) begin
            ext_addr = byte_addr[EADDR_W-1:0];
        end else if (w16) begin
            ext_addr = byte_addr[EADDR_W:1];
        end else begin
            ext_addr = byte_addr[EADDR_W+1:2];
        end
    end
endmodule

// File: rtl/ews_lane_mux.sv
// Module: ews_lane_mux
// Routes the addressed half-word or word of the internal write data to the
// low external lanes, and merges returned read data into its own lane of
// the accumulated internal word. Combinational; lane select is byte-address
// bits [2:1].
module ews_lane_mux
    import ews_pkg::*;
(
    input  logic [1:0]         hsel,
    input  logic               w16,
    input  logic [IDATA_W-1:0] wdata,
    input  logic [IDATA_W-1:0] rdata_acc,
    input  logic [EDATA_W-1:0] ext_rdata,
    output logic [EDATA_W-1:0] ext_wdata,
    output logic [IDATA_W-1:0] rdata_next
);
    localparam int LANES = IDATA_W / HW_W;

    // Select the outgoing half-word or word.
    always_comb begin
        if (w16) begin
            ext_wdata = {{(EDATA_W-HW_W){1'b0}}, wdata[HW_W*hsel +: HW_W]};
        end else begin
            ext_wdata = wdata[EDATA_W*hsel[1] +: EDATA_W];
        end
    end

    // One merge slice per internal half-word lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [1:0] LANE = 2'(g);
        logic            hit;
        logic [HW_W-1:0] src;
        assign hit = w16 ? (hsel == LANE) : (hsel[1] == LANE[1]);
        assign src = w16 ? ext_rdata[HW_W-1:0] : ext_rdata[HW_W*(g%2) +: HW_W];
        assign rdata_next[HW_W*g +: HW_W] = hit ? src : rdata_acc[HW_W*g +: HW_W];
    end
endmodule

// File: rtl/ext_width_splitter.sv
// Module: ext_width_splitter
// Accepts one internal access while idle and issues the matching sequence
// of narrow external cycles, one per acknowledgement. Gathers read data and
// pulses done after the last one. Region settings are latched at acceptance.
// Assumes ext_ack is only meaningful while ext_valid is high.
module ext_width_splitter
    import ews_pkg::*;
#(
    parameter int IADDR_W = 26,
    parameter int EADDR_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [1:0]         req_size,
    input  logic [IADDR_W-1:0] req_addr,
    input  logic [IDATA_W-1:0] req_wdata,
    input  logic [1:0]         cfg_portw,
    input  logic               cfg_align,
    input  logic               cfg_big_endian,
    output logic               ext_valid,
    output logic               ext_write,
    output logic [EADDR_W-1:0] ext_addr,
    output logic [EDATA_W-1:0] ext_wdata,
    input  logic               ext_ack,
    input  logic [EDATA_W-1:0] ext_rdata,
    output logic               done,
    output logic [IDATA_W-1:0] rdata,
    output logic               err
);
    ews_state_t         state_q;
    logic [1:0]         idx_q;
    logic [1:0]         last_q;
    logic               w16_q;
    logic               be_q;
    logic               align_q;
    logic               write_q;
    logic [IADDR_W-1:0] base_q;
    logic [IDATA_W-1:0] wdata_q;
    logic [IDATA_W-1:0] rdata_q;
    logic               done_q;
    logic               err_q;

    logic               plan_bad;
    logic               plan_w16;
    logic [1:0]         plan_last;
    logic [2:0]         plan_clear;
    logic [IADDR_W-1:0] req_base;
    logic [IADDR_W-1:0] cur_byte;
    logic [IDATA_W-1:0] rdata_merged;

    ews_beat_plan u_plan (
        .size      (req_size),
        .portw     (cfg_portw),
        .bad       (plan_bad),
        .w16       (plan_w16),
        .last_idx  (plan_last),
        .low_clear (plan_clear)
    );

    // Clear the address bits below the access size.
    assign req_base = {req_addr[IADDR_W-1:3], req_addr[2:0] & ~plan_clear};

    ews_addr_gen #(
        .IADDR_W (IADDR_W),
        .EADDR_W (EADDR_W)
    ) u_addr (
        .base       (base_q),
        .idx        (idx_q),
        .last_idx   (last_q),
        .w16        (w16_q),
        .big_endian (be_q),
        .align      (align_q),
        .byte_addr  (cur_byte),
        .ext_addr   (ext_addr)
    );

    ews_lane_mux u_lanes (
        .hsel       (cur_byte[2:1]),
        .w16        (w16_q),
        .wdata      (wdata_q),
        .rdata_acc  (rdata_q),
        .ext_rdata  (ext_rdata),
        .ext_wdata  (ext_wdata),
        .rdata_next (rdata_merged)
    );

    // Sequence control, request latching and read gathering.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= 2'd0;
            last_q  <= 2'd0;
            w16_q   <= 1'b0;
            be_q    <= 1'b0;
            align_q <= 1'b0;
            write_q <= 1'b0;
            base_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    done_q <= 1'b0;
                    err_q  <= 1'b0;
                    if (req_valid) begin
                        if (plan_bad) begin
                            err_q <= 1'b1;
                        end else begin
                            state_q <= ST_BUS;
                            idx_q   <= 2'd0;
                            last_q  <= plan_last;
                            w16_q   <= plan_w16;
                            be_q    <= cfg_big_endian;
                            align_q <= cfg_align;
                            write_q <= req_write;
                            base_q  <= req_base;
                            wdata_q <= req_wdata;
                            if (!req_write) begin
                                rdata_q <= '0;
                            end
                        end
                    end
                end
                ST_BUS: begin
                    if (ext_ack) begin
                        if (!write_q) begin
                            rdata_q <= rdata_merged;
                        end
                        if (idx_q == last_q) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            idx_q <= idx_q + 2'd1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign ext_valid = (state_q == ST_BUS);
    assign ext_write = write_q;
    assign done      = done_q;
    assign err       = err_q;
    assign rdata     = rdata_q;
endmodule

// File: rtl/ews_checker.sv
// Module: ews_checker
// Temporal properties of the splitter, attached to every instance by bind.
module ews_checker #(
    parameter int EADDR_W = 24,
    parameter int EDATA_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_ready,
    input logic               ext_valid,
    input logic               ext_ack,
    input logic [EADDR_W-1:0] ext_addr,
    input logic [EDATA_W-1:0] ext_wdata,
    input logic               done,
    input logic               err,
    input logic               w16_q
);
    // R1: an error never comes with a bus cycle or a done.
    p_err_no_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!ext_valid && !done));

    // R10: no new request is offered while a cycle is outstanding.
    p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ext_valid |-> !req_ready);

    // R10: an unacknowledged cycle holds its address and data.
    p_hold_until_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_valid && !ext_ack) |=> (ext_valid && $stable(ext_addr) && $stable(ext_wdata)));

    // R9: done only follows an acknowledged cycle.
    p_done_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(ext_valid && ext_ack));

    // R9: done lasts one cycle.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: upper lanes are quiet in a 16-bit region.
    p_upper_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_valid && w16_q) |-> (ext_wdata[EDATA_W-1:16] == '0));
endmodule

bind ext_width_splitter ews_checker #(
    .EADDR_W (EADDR_W),
    .EDATA_W (ews_pkg::EDATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .ext_valid (ext_valid),
    .ext_ack   (ext_ack),
    .ext_addr  (ext_addr),
    .ext_wdata (ext_wdata),
    .done      (done),
    .err       (err),
    .w16_q     (w16_q)
);

// File: tb/ext_width_splitter_bench.sv
`timescale 1ns/1ps
module ext_width_splitter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [25:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [1:0]  cfg_portw = 2'b01;
    logic        cfg_align = 1'b0;
    logic        cfg_big_endian = 1'b0;
    logic        ext_valid;
    logic        ext_write;
    logic [23:0] ext_addr;
    logic [31:0] ext_wdata;
    logic        ext_ack = 1'b0;
    logic [31:0] ext_rdata = '0;
    logic        done;
    logic [63:0] rdata;
    logic        err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    ext_width_splitter u_ext_width_splitter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .cfg_portw(cfg_portw), .cfg_align(cfg_align),
        .cfg_big_endian(cfg_big_endian), .ext_valid(ext_valid), .ext_write(ext_write),
        .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_ack(ext_ack),
        .ext_rdata(ext_rdata), .done(done), .rdata(rdata), .err(err)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // One request end to end, against a behavioural expectation.
    task automatic run(input bit wr, input logic [1:0] sz, input logic [25:0] a,
                       input logic [63:0] wd, input logic [1:0] pw, input bit al,
                       input bit be, input int dly);
        bit          reserved;
        bit          w16;
        int          n;
        logic [25:0] base;
        logic [25:0] ba;
        logic [25:0] shifted;
        logic [23:0] ea;
        logic [31:0] ew;
        logic [31:0] rv;
        logic [63:0] exp_rd;
        int          off;
        int          k;
        string       ordtag;
        string       adrtag;
        reserved = (pw == 2'b00) || (pw == 2'b11) || (sz == 2'd3);
        @(negedge clk);
        check(req_ready == 1'b1, "R10 ready when idle", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a;
        req_wdata = wd; cfg_portw = pw; cfg_align = al; cfg_big_endian = be;
        @(negedge clk);
        req_valid = 1'b0;
        // Settings move after acceptance; the design must not follow them.
        cfg_portw = ~pw; cfg_align = ~al; cfg_big_endian = ~be;
        req_addr = ~a; req_wdata = ~wd; req_size = 2'd3;
        if (reserved) begin
            check(err == 1'b1, "R1 err pulse", 64'(err), 64'd1);
            check(ext_valid == 1'b0, "R1 no bus cycle", 64'(ext_valid), 64'd0);
            @(negedge clk);
            check(err == 1'b0 && done == 1'b0 && ext_valid == 1'b0,
                  "R1 err single cycle", {61'd0, err, done, ext_valid}, 64'd0);
            return;
        end
        check(err == 1'b0, "R1 no err on legal code", 64'(err), 64'd0);
        w16 = (pw == 2'b01);
        if (w16) n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        else     n = (sz == 2'd2) ? 2 : 1;
        base = a & ~((sz == 2'd0) ? 26'd1 : (sz == 2'd1) ? 26'd3 : 26'd7);
        ordtag = w16 ? (be ? "R3" : "R2") : "R4";
        adrtag = al ? "R6" : "R5";
        exp_rd = '0;
        for (int b = 0; b < n; b++) begin
            if (w16) begin
                k = (be && n > 1) ? (b ^ 1) : b;
                off = 2 * k;
            end else begin
                off = 4 * b;
            end
            ba = base | 26'(off);
            shifted = !al ? ba : (w16 ? (ba >> 1) : (ba >> 2));
            ea = shifted[23:0];
            for (int d = 0; d < dly; d++) begin
                check(ext_valid == 1'b1 && req_ready == 1'b0, "R10 busy while waiting",
                      {62'd0, ext_valid, req_ready}, 64'd2);
                check(ext_addr == ea, "R10 address held", 64'(ext_addr), 64'(ea));
                req_valid = 1'b1;
                @(negedge clk);
            end
            req_valid = 1'b0;
            check(ext_valid == 1'b1 && ext_write == wr, "R10 cycle present",
                  {62'd0, ext_valid, ext_write}, {62'd0, 1'b1, wr});
            check(ext_addr == ea, $sformatf("%s %s beat %0d address", ordtag, adrtag, b),
                  64'(ext_addr), 64'(ea));
            if (wr) begin
                ew = w16 ? {16'h0, wd[16*ba[2:1] +: 16]} : wd[32*ba[2] +: 32];
                check(ext_wdata == ew, "R7 write lane", 64'(ext_wdata), 64'(ew));
            end
            rv = $urandom;
            if (w16) exp_rd[16*ba[2:1] +: 16] = rv[15:0];
            else     exp_rd[32*ba[2] +: 32] = rv;
            ext_rdata = rv;
            ext_ack = 1'b1;
            @(negedge clk);
            ext_ack = 1'b0;
            ext_rdata = $urandom;
        end
        check(done == 1'b1, "R9 done after last ack", 64'(done), 64'd1);
        check(ext_valid == 1'b0, $sformatf("%s cycle count", ordtag), 64'(ext_valid), 64'd0);
        if (!wr) check(rdata == exp_rd, "R8 gathered read data", rdata, exp_rd);
        @(negedge clk);
        check(done == 1'b0, "R9 done one cycle", 64'(done), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && ext_valid == 1'b0, "R10 reset idle",
              {62'd0, req_ready, ext_valid}, 64'd2);
        check(done == 1'b0 && err == 1'b0 && rdata == 64'd0, "R9 reset outputs",
              {rdata[61:0], done, err}, 64'd0);

        run(1, 2'd2, 26'h0123458, 64'h1111_2222_3333_4444, 2'b01, 0, 0, 0);
        run(0, 2'd2, 26'h2345670, 64'h0, 2'b01, 1, 1, 2);
        run(1, 2'd1, 26'h0ABCDE4, 64'h8765_4321_CAFE_F00D, 2'b01, 1, 1, 1);
        run(0, 2'd1, 26'h1000008, 64'h0, 2'b01, 0, 0, 0);
        run(0, 2'd0, 26'h3FFFFF6, 64'h0, 2'b01, 1, 1, 0);
        run(1, 2'd0, 26'h0000002, 64'hAAAA_BBBB_CCCC_DDDD, 2'b01, 0, 1, 0);
        run(1, 2'd2, 26'h1234560, 64'hDEAD_BEEF_0BAD_F00D, 2'b10, 1, 0, 1);
        run(0, 2'd1, 26'h2000004, 64'h0, 2'b10, 1, 1, 0);
        run(0, 2'd0, 26'h0000002, 64'h0, 2'b10, 0, 0, 3);
        run(0, 2'd2, 26'h3FFFFF8, 64'h0, 2'b10, 0, 0, 0);
        run(0, 2'd2, 26'h0000010, 64'h0, 2'b00, 0, 0, 0);
        run(1, 2'd1, 26'h0000010, 64'h5, 2'b11, 1, 1, 0);
        run(0, 2'd3, 26'h0000010, 64'h0, 2'b01, 0, 0, 0);

        for (int i = 0; i < 60; i++) begin
            logic [1:0]  rsz;
            logic [1:0]  rpw;
            rsz = 2'($urandom_range(0, 2));
            rpw = ($urandom_range(0, 9) == 0) ? 2'b11 : 2'($urandom_range(1, 2));
            run(1'($urandom), rsz, 26'($urandom), {32'($urandom), 32'($urandom)},
                rpw, 1'($urandom), 1'($urandom), $urandom_range(0, 3));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule